// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

This block sits between two parallel buses, called the A side and the B side. The bus is split into independent lanes (two lanes of eight bits by default). Each lane holds two storage registers, one for each direction of transfer. The A-to-B register of a lane samples the lane's A-side data on a rising edge of that lane's A-to-B capture clock, but only while its active-low capture enable is low. The stored value is presented on the lane's B-side output. An active-low drive enable decides whether the lane's B-side pins are actually driven or left at high impedance. The B-to-A path is a mirror image, with its own clock, capture enable and drive enable. Tying the matching controls of all lanes together turns the block into one full-width transceiver.

Each bidirectional pin is split into an input, an output and a per-bit output enable, so an outer pad ring or wrapper can form the real tri-state pin. An optional keeper (parameter `KEEP_EN`) models bus hold. A per-bit float flag marks a data input whose driver has gone to high impedance. A floating bit is replaced by the last value the keeper saw on it while it was driven.

Each lane also raises a contention flag when both of its directions are enabled to drive at the same time. Other logic or a bench can watch this flag.

Top module: `xcvr_dual_lane`

## Requirements
- R1: An active-low asynchronous reset clears all four lane registers to zero, so `a_out` and `b_out` read 16'h0000 after reset.
- R2: On a rising edge of `cap_clk_ab[l]` with `cap_en_n_ab[l]` low (0 = capture), the lane-l slice of `b_out` takes the lane-l slice of the effective A-side data.
- R3: On a rising edge of `cap_clk_ab[l]` or `cap_clk_ba[l]` with the matching capture enable high (1 = hold), the register keeps its old contents.
- R4: A change of `a_in` or `b_in` with no rising capture clock edge leaves `a_out` and `b_out` unchanged, because the outputs show the stored value and not the live input.
- R5: The B-to-A path captures the B-side data into `a_out` under `cap_clk_ba[l]` and `cap_en_n_ba[l]`, with the same rules as R2 and R3.
- R6: All eight `b_oe` bits of lane l are 1 when `drv_en_n_ab[l]` is 0 and all are 0 (high impedance) when it is 1; the same holds for `a_oe` and `drv_en_n_ba[l]`. `b_out` and `a_out` keep reporting the register while disabled.
- R7: Lane l occupies bits [8*l+7 : 8*l] of every data vector, and the controls of lane l affect only that slice.
- R8: `clash[l]` is 1 exactly when `drv_en_n_ab[l]` and `drv_en_n_ba[l]` are both 0.
- R9: With `KEEP_EN` = 1, a data bit whose float flag is 1 is captured as the value that bit carried at the most recent rising edge of that direction's capture clock at which it was not floating, or 0 if there has been no such edge since reset. The keeper is updated at every edge of that clock, whether or not the capture enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_clk_ab | input | LANES | Per-lane A-to-B capture clock |
| cap_en_n_ab | input | LANES | Per-lane A-to-B capture enable, active low |
| drv_en_n_ab | input | LANES | Per-lane B-side drive enable, active low |
| cap_clk_ba | input | LANES | Per-lane B-to-A capture clock |
| cap_en_n_ba | input | LANES | Per-lane B-to-A capture enable, active low |
| drv_en_n_ba | input | LANES | Per-lane A-side drive enable, active low |
| a_in | input | LANES*LANE_W | A-side pin input value |
| a_float | input | LANES*LANE_W | Per-bit flag, 1 = A-side driver is at high impedance |
| a_out | output | LANES*LANE_W | Stored B-to-A data for the A-side pins |
| a_oe | output | LANES*LANE_W | Per-bit A-side output enable, 1 = drive |
| b_in | input | LANES*LANE_W | B-side pin input value |
| b_float | input | LANES*LANE_W | Per-bit flag, 1 = B-side driver is at high impedance |
| b_out | output | LANES*LANE_W | Stored A-to-B data for the B-side pins |
| b_oe | output | LANES*LANE_W | Per-bit B-side output enable, 1 = drive |
| clash | output | LANES | Per-lane flag, both directions enabled to drive |

## Verification
The assertions check every capture clock edge: a low capture enable must load the effective input seen at the edge before, and a high enable must leave the register unchanged. They also check that the registers read zero before the first edge after reset. Both drive enables and the contention flag are checked continuously. Some behaviour only the bench's scenarios show: that the keeper substitutes the right remembered value for partly floating bytes, that input changes without an edge never reach the outputs, and that one lane's controls leave the other lane's slice alone.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned DFLT_LANES  = 2;
    localparam int unsigned DFLT_LANE_W = 8;

    // Meaning of an active-low capture enable sampled at a clock edge
    typedef enum logic {
        CAP_TAKE = 1'b0,
        CAP_HOLD = 1'b1
    } cap_mode_e;

    // Meaning of an active-low drive enable
    typedef enum logic {
        DRV_ON  = 1'b0,
        DRV_OFF = 1'b1
    } drv_mode_e;

endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int W       = 8,
    parameter int KEEP_EN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] floating,
    output logic [W-1:0] eff
);

    generate
        if (KEEP_EN != 0) begin : g_keep
            logic [W-1:0] kept;

            for (genvar i = 0; i < W; i++) begin : g_bit
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        kept[i] <= 1'b0;
                    end else if (!floating[i]) begin
                        kept[i] <= din[i];
                    end
                end

                always_comb begin
                    eff[i] = floating[i] ? kept[i] : din[i];
                end
            end
        end else begin : g_pass
            always_comb begin
                eff = din | (floating & '0);
            end
        end
    endgenerate

endmodule

// File: rtl/xcvr_dir_reg.sv
module xcvr_dir_reg
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en_n,
    input  logic         drv_en_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] oe
);

    // storage register: one process, selected by the capture mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (cap_mode_e'(cap_en_n))
                CAP_TAKE: q <= din;
                CAP_HOLD: q <= q;
            endcase
        end
    end

    // output enable: one process, selected by the drive mode
    always_comb begin
        unique case (drv_mode_e'(drv_en_n))
            DRV_ON:  oe = '1;
            DRV_OFF: oe = '0;
        endcase
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W       = 8,
    parameter int KEEP_EN = 1
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         cen_ab_n,
    input  logic         den_ab_n,
    input  logic         clk_ba,
    input  logic         cen_ba_n,
    input  logic         den_ba_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_flt,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_flt,
    output logic [W-1:0] a_eff,
    output logic [W-1:0] b_eff,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         clash
);

    // A side feeds the A-to-B register
    xcvr_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_a (
        .clk      (clk_ab),
        .rst_n    (rst_n),
        .din      (a_in),
        .floating (a_flt),
        .eff      (a_eff)
    );

    xcvr_dir_reg #(.W(W)) u_reg_ab (
        .clk      (clk_ab),
        .rst_n    (rst_n),
        .cap_en_n (cen_ab_n),
        .drv_en_n (den_ab_n),
        .din      (a_eff),
        .q        (b_out),
        .oe       (b_oe)
    );

    // B side feeds the B-to-A register
    xcvr_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_b (
        .clk      (clk_ba),
        .rst_n    (rst_n),
        .din      (b_in),
        .floating (b_flt),
        .eff      (b_eff)
    );

    xcvr_dir_reg #(.W(W)) u_reg_ba (
        .clk      (clk_ba),
        .rst_n    (rst_n),
        .cap_en_n (cen_ba_n),
        .drv_en_n (den_ba_n),
        .din      (b_eff),
        .q        (a_out),
        .oe       (a_oe)
    );

    always_comb begin
        clash = ~den_ab_n & ~den_ba_n;
    end

endmodule

// File: rtl/xcvr_dual_lane.sv
module xcvr_dual_lane
    import xcvr_pkg::*;
#(
    parameter  int LANES   = DFLT_LANES,
    parameter  int LANE_W  = DFLT_LANE_W,
    parameter  int KEEP_EN = 1,
    localparam int BUS_W   = LANES * LANE_W
) (
    input  logic             rst_n,
    input  logic [LANES-1:0] cap_clk_ab,
    input  logic [LANES-1:0] cap_en_n_ab,
    input  logic [LANES-1:0] drv_en_n_ab,
    input  logic [LANES-1:0] cap_clk_ba,
    input  logic [LANES-1:0] cap_en_n_ba,
    input  logic [LANES-1:0] drv_en_n_ba,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] a_float,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    input  logic [BUS_W-1:0] b_float,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_oe,
    output logic [LANES-1:0] clash
);

    // effective (keeper-resolved) data seen by each register
    logic [BUS_W-1:0] a_eff;
    logic [BUS_W-1:0] b_eff;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            xcvr_lane #(.W(LANE_W), .KEEP_EN(KEEP_EN)) u_lane (
                .rst_n    (rst_n),
                .clk_ab   (cap_clk_ab[l]),
                .cen_ab_n (cap_en_n_ab[l]),
                .den_ab_n (drv_en_n_ab[l]),
                .clk_ba   (cap_clk_ba[l]),
                .cen_ba_n (cap_en_n_ba[l]),
                .den_ba_n (drv_en_n_ba[l]),
                .a_in     (a_in[l*LANE_W +: LANE_W]),
                .a_flt    (a_float[l*LANE_W +: LANE_W]),
                .b_in     (b_in[l*LANE_W +: LANE_W]),
                .b_flt    (b_float[l*LANE_W +: LANE_W]),
                .a_eff    (a_eff[l*LANE_W +: LANE_W]),
                .b_eff    (b_eff[l*LANE_W +: LANE_W]),
                .a_out    (a_out[l*LANE_W +: LANE_W]),
                .a_oe     (a_oe[l*LANE_W +: LANE_W]),
                .b_out    (b_out[l*LANE_W +: LANE_W]),
                .b_oe     (b_oe[l*LANE_W +: LANE_W]),
                .clash    (clash[l])
            );
        end
    endgenerate

endmodule

// File: rtl/xcvr_dual_lane_chk.sv
module xcvr_dual_lane_chk #(
    parameter  int LANES  = 2,
    parameter  int LANE_W = 8,
    localparam int BUS_W  = LANES * LANE_W
) (
    input logic             rst_n,
    input logic [LANES-1:0] cap_clk_ab,
    input logic [LANES-1:0] cap_en_n_ab,
    input logic [LANES-1:0] drv_en_n_ab,
    input logic [LANES-1:0] cap_clk_ba,
    input logic [LANES-1:0] cap_en_n_ba,
    input logic [LANES-1:0] drv_en_n_ba,
    input logic [BUS_W-1:0] a_eff,
    input logic [BUS_W-1:0] b_eff,
    input logic [BUS_W-1:0] a_out,
    input logic [BUS_W-1:0] a_oe,
    input logic [BUS_W-1:0] b_out,
    input logic [BUS_W-1:0] b_oe,
    input logic [LANES-1:0] clash
);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_chk
            // armed = at least one edge of this clock since reset
            logic armed_ab;
            logic armed_ba;

            always_ff @(posedge cap_clk_ab[l] or negedge rst_n) begin
                if (!rst_n) armed_ab <= 1'b0;
                else        armed_ab <= 1'b1;
            end

            always_ff @(posedge cap_clk_ba[l] or negedge rst_n) begin
                if (!rst_n) armed_ba <= 1'b0;
                else        armed_ba <= 1'b1;
            end

            assert_reset_clear_ab_R1: assert property (
                @(posedge cap_clk_ab[l]) disable iff (!rst_n)
                !armed_ab |-> b_out[l*LANE_W +: LANE_W] == '0);

            assert_reset_clear_ba_R1: assert property (
                @(posedge cap_clk_ba[l]) disable iff (!rst_n)
                !armed_ba |-> a_out[l*LANE_W +: LANE_W] == '0);

            assert_capture_ab_R2: assert property (
                @(posedge cap_clk_ab[l]) disable iff (!rst_n)
                (armed_ab && !$past(cap_en_n_ab[l]))
                |-> b_out[l*LANE_W +: LANE_W] == $past(a_eff[l*LANE_W +: LANE_W]));

            assert_hold_ab_R3: assert property (
                @(posedge cap_clk_ab[l]) disable iff (!rst_n)
                (armed_ab && $past(cap_en_n_ab[l]))
                |-> $stable(b_out[l*LANE_W +: LANE_W]));

            assert_capture_ba_R5: assert property (
                @(posedge cap_clk_ba[l]) disable iff (!rst_n)
                (armed_ba && !$past(cap_en_n_ba[l]))
                |-> a_out[l*LANE_W +: LANE_W] == $past(b_eff[l*LANE_W +: LANE_W]));

            assert_hold_ba_R5: assert property (
                @(posedge cap_clk_ba[l]) disable iff (!rst_n)
                (armed_ba && $past(cap_en_n_ba[l]))
                |-> $stable(a_out[l*LANE_W +: LANE_W]));

            always_comb begin
                if (rst_n === 1'b1) begin
                    assert_oe_b_R6: assert (
                        ($countones(b_oe[l*LANE_W +: LANE_W]) == (drv_en_n_ab[l] ? 0 : LANE_W)))
                        else $error("b_oe lane %0d disagrees with drive enable", l);
                    assert_oe_a_R6: assert (
                        ($countones(a_oe[l*LANE_W +: LANE_W]) == (drv_en_n_ba[l] ? 0 : LANE_W)))
                        else $error("a_oe lane %0d disagrees with drive enable", l);
                    assert_clash_R8: assert (
                        clash[l] == ((b_oe[l*LANE_W] == 1'b1) && (a_oe[l*LANE_W] == 1'b1)))
                        else $error("clash lane %0d wrong", l);
                end
            end
        end
    endgenerate

endmodule

bind xcvr_dual_lane xcvr_dual_lane_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/xcvr_dual_lane_test.sv
module xcvr_dual_lane_test;

    localparam int CLK_PERIOD = 10;

    logic        sys_clk     = 1'b0;
    logic        rst_n       = 1'b0;
    logic [1:0]  cap_clk_ab  = 2'b00;
    logic [1:0]  cap_en_n_ab = 2'b11;
    logic [1:0]  drv_en_n_ab = 2'b00;
    logic [1:0]  cap_clk_ba  = 2'b00;
    logic [1:0]  cap_en_n_ba = 2'b11;
    logic [1:0]  drv_en_n_ba = 2'b00;
    logic [15:0] a_in        = 16'h0000;
    logic [15:0] a_float     = 16'h0000;
    logic [15:0] b_in        = 16'h0000;
    logic [15:0] b_float     = 16'h0000;
    logic [15:0] a_out;
    logic [15:0] a_oe;
    logic [15:0] b_out;
    logic [15:0] b_oe;
    logic [1:0]  clash;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [15:0] m_b    = 16'h0000;
    logic [15:0] m_a    = 16'h0000;
    logic [15:0] m_ka   = 16'h0000;
    logic [15:0] m_kb   = 16'h0000;

    xcvr_dual_lane uut (
        .rst_n       (rst_n),
        .cap_clk_ab  (cap_clk_ab),
        .cap_en_n_ab (cap_en_n_ab),
        .drv_en_n_ab (drv_en_n_ab),
        .cap_clk_ba  (cap_clk_ba),
        .cap_en_n_ba (cap_en_n_ba),
        .drv_en_n_ba (drv_en_n_ba),
        .a_in        (a_in),
        .a_float     (a_float),
        .a_out       (a_out),
        .a_oe        (a_oe),
        .b_in        (b_in),
        .b_float     (b_float),
        .b_out       (b_out),
        .b_oe        (b_oe),
        .clash       (clash)
    );

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model of one set of capture edges
    task automatic model_edge(input logic [1:0] ab_mask, input logic [1:0] ba_mask);
        for (int l = 0; l < 2; l++) begin
            for (int k = 0; k < 8; k++) begin
                int i = l * 8 + k;
                if (ab_mask[l]) begin
                    logic e = a_float[i] ? m_ka[i] : a_in[i];
                    if (!cap_en_n_ab[l]) m_b[i] = e;
                    if (!a_float[i]) m_ka[i] = a_in[i];
                end
                if (ba_mask[l]) begin
                    logic e = b_float[i] ? m_kb[i] : b_in[i];
                    if (!cap_en_n_ba[l]) m_a[i] = e;
                    if (!b_float[i]) m_kb[i] = b_in[i];
                end
            end
        end
    endtask

    task automatic cycle(input logic [1:0] ab_mask, input logic [1:0] ba_mask);
        @(posedge sys_clk);
        #2;
        cap_clk_ab = ab_mask;
        cap_clk_ba = ba_mask;
        model_edge(ab_mask, ba_mask);
        #2;
        cap_clk_ab = 2'b00;
        cap_clk_ba = 2'b00;
        @(negedge sys_clk);
        #1;
    endtask

    function automatic logic [15:0] exp_oe(input logic [1:0] den_n);
        logic [15:0] r = 16'h0000;
        for (int l = 0; l < 2; l++)
            if (den_n[l] == 1'b0) r[l*8 +: 8] = 8'hFF;
        return r;
    endfunction

    // per-clock comparison against the reference model
    always @(negedge sys_clk) begin
        if (rst_n) begin
            check("R2 b_out vs model", b_out, m_b);
            check("R5 a_out vs model", a_out, m_a);
            check("R6 b_oe vs model", b_oe, exp_oe(drv_en_n_ab));
            check("R6 a_oe vs model", a_oe, exp_oe(drv_en_n_ba));
            check("R8 clash vs model", {14'h0, clash}, {14'h0, ~drv_en_n_ab & ~drv_en_n_ba});
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge sys_clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        #(CLK_PERIOD * 2);
        // R1: outputs clear while reset held
        check("R1 b_out in reset", b_out, 16'h0000);
        check("R1 a_out in reset", a_out, 16'h0000);
        @(negedge sys_clk);
        rst_n = 1'b1;
        @(negedge sys_clk);
        #1;

        // R2 with R7: capture lane 0 only
        a_in = 16'hA55A;
        cap_en_n_ab = 2'b00;
        cycle(2'b01, 2'b00);
        check("R2 R7 lane0 capture", b_out, 16'h005A);

        // R3: enable high, edge present
        a_in = 16'h1234;
        cap_en_n_ab = 2'b11;
        cycle(2'b01, 2'b00);
        check("R3 hold with enable high", b_out, 16'h005A);

        // R4: input change, no edge
        a_in = 16'hFFFF;
        cap_en_n_ab = 2'b00;
        cycle(2'b00, 2'b00);
        check("R4 no edge", b_out, 16'h005A);

        // R7: lane 1 only
        a_in = 16'hC3FF;
        cycle(2'b10, 2'b00);
        check("R7 lane1 capture", b_out, 16'hC35A);

        // R5: B-to-A both lanes
        b_in = 16'h9E7B;
        cap_en_n_ba = 2'b00;
        cycle(2'b00, 2'b11);
        check("R5 B-to-A capture", a_out, 16'h9E7B);
        check("R5 B-to-A leaves b_out", b_out, 16'hC35A);

        // R6 and R8: disable B drive on lane 0
        drv_en_n_ab = 2'b01;
        cycle(2'b00, 2'b00);
        check("R6 b_oe lane0 off", b_oe, 16'hFF00);
        check("R6 b_out kept while off", b_out, 16'hC35A);
        check("R8 clash lane1 only", {14'h0, clash}, 16'h0002);

        drv_en_n_ab = 2'b11;
        drv_en_n_ba = 2'b11;
        cycle(2'b00, 2'b00);
        check("R6 all off", b_oe | a_oe, 16'h0000);
        check("R8 no clash", {14'h0, clash}, 16'h0000);

        // R9: load keeper with a hold edge, then float
        a_in = 16'h003C;
        cap_en_n_ab = 2'b01;
        cycle(2'b01, 2'b00);
        check("R9 keeper load no capture", b_out, 16'hC35A);

        a_in = 16'h0000;
        a_float = 16'h00FF;
        cap_en_n_ab = 2'b00;
        cycle(2'b01, 2'b00);
        check("R9 fully floating byte", b_out, 16'hC33C);

        a_in = 16'h0081;
        a_float = 16'h000F;
        cycle(2'b01, 2'b00);
        check("R9 half floating byte", b_out, 16'hC38C);

        // R1: reset mid-run
        a_float = 16'h0000;
        rst_n = 1'b0;
        #1;
        m_a = 16'h0000; m_b = 16'h0000; m_ka = 16'h0000; m_kb = 16'h0000;
        check("R1 b_out after reset", b_out, 16'h0000);
        check("R1 a_out after reset", a_out, 16'h0000);
        @(negedge sys_clk);
        rst_n = 1'b1;
        cycle(2'b00, 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule